// File: doc/BRIEF.md
# Two-Channel Threshold Interrupt with Persistence Filter

This block watches two streams of sensor results. The first is a wide ambient-light count and the second is a narrower proximity count. Each new result is compared against a programmable upper and lower bound. An event is recorded only after a programmable run of consecutive results has fallen outside the window on the same side. Recorded events collect in one 8-bit flag byte, and that byte also holds two sunlight-protection events. Any set flag pulls a single active-low interrupt line low.

The host reads the flag byte through its own register path and pulses `flag_rd` during that access. The pulse clears every flag, and the interrupt line then returns high. The two channels count persistence differently. The ambient persistence code selects a power-of-two run length. The proximity persistence code selects a linear run length. Either channel can be shut down, and each event class has its own enable.

Top module: `sense_irq_top`

## Requirements
- R1: An ambient result strictly greater than `amb_thr_hi` is "above". Otherwise, a result strictly less than `amb_thr_lo` is "below". "Above" sets flag bit 4 and "below" sets flag bit 5, so "above" takes precedence when the bounds overlap.
- R2: Ambient persistence code 0, 1, 2 or 3 requires 1, 2, 4 or 8 consecutive valid results outside the window on the same side. The flag is set on the result that completes the run, and again on every further result while the run continues.
- R3: A proximity result strictly greater than `prx_thr_hi` sets flag bit 1 (close). Otherwise, a result strictly less than `prx_thr_lo` sets flag bit 0 (away). A result between the bounds, inclusive, sets no flag.
- R4: Proximity persistence code 0, 1, 2 or 3 requires 1, 2, 3 or 4 consecutive same-side results.
- R5: A valid result inside the window sets that channel's run count to zero. A valid result on the opposite side from the previous one restarts the run at one.
- R6: While a channel's shut-down input is high, its valid results neither count nor set flags, and its run count is cleared.
- R7: Ambient flags are set only while `amb_int_en` is high. Proximity flags are set only while `prx_int_en` is high. Sunlight flags are set only while `sun_int_en` is high.
- R8: A `sun_enter` pulse sets flag bit 6, and a `sun_leave` pulse sets flag bit 7.
- R9: Flags stay set until they are read. Bits 3 and 2 always read zero. `int_n` is low exactly when any flag is set.
- R10: A `flag_rd` pulse clears all flags. A flag set in the same cycle as the read remains set.
- R11: During reset, all flags are zero, `int_n` is high, and both run counts are zero.
- R12: A flag caused by a valid result or a sunlight pulse becomes visible after the first rising clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| amb_valid | input | 1 | Ambient result strobe |
| amb_sample | input | AMB_W | Ambient result |
| amb_thr_hi | input | AMB_W | Ambient upper bound |
| amb_thr_lo | input | AMB_W | Ambient lower bound |
| amb_pers | input | 2 | Ambient persistence code |
| amb_int_en | input | 1 | Ambient event enable |
| amb_shut | input | 1 | Ambient channel shut down |
| prx_valid | input | 1 | Proximity result strobe |
| prx_sample | input | PRX_W | Proximity result |
| prx_thr_hi | input | PRX_W | Proximity upper bound |
| prx_thr_lo | input | PRX_W | Proximity lower bound |
| prx_pers | input | 2 | Proximity persistence code |
| prx_int_en | input | 1 | Proximity event enable |
| prx_shut | input | 1 | Proximity channel shut down |
| sun_int_en | input | 1 | Sunlight event enable |
| sun_enter | input | 1 | Sunlight protection entered, one-cycle pulse |
| sun_leave | input | 1 | Sunlight protection left, one-cycle pulse |
| flag_rd | input | 1 | Flag byte read, clears all flags |
| flags | output | 8 | Flag byte |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with AMB_W=6 and PRX_W=4. At these widths every proximity result can be swept against every pair of bounds. Every ambient result is swept against a grid of bound pairs that includes overlapping, equal and extreme bounds. All four persistence codes of both channels are walked to their full run length. The bench also drives directed sequences for the following cases:
- an in-window result breaking a run;
- a change of side restarting a run;
- shut-down clearing a partial run;
- a read colliding with a new event.

// File: rtl/sense_irq_pkg.sv
package sense_irq_pkg;

    localparam int FLAG_W = 8;
    localparam int CNT_W  = 4;

    // Flag byte bit positions (host decodes these).
    localparam int FB_PRX_AWAY  = 0;
    localparam int FB_PRX_CLOSE = 1;
    localparam int FB_AMB_HI    = 4;
    localparam int FB_AMB_LO    = 5;
    localparam int FB_SUN_ENTER = 6;
    localparam int FB_SUN_LEAVE = 7;

    localparam logic [FLAG_W-1:0] RSV_MASK = 8'h0C;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        WIN_IN    = 2'd0,
        WIN_ABOVE = 2'd1,
        WIN_BELOW = 2'd2
    } win_e;

    typedef struct packed {
        logic fire_hi;
        logic fire_lo;
    } evt_t;

    // Run length demanded by a persistence code.
    function automatic cnt_t persist_target(input logic pow2, input logic [1:0] code);
        cnt_t t;
        if (pow2) t = cnt_t'(1) << code;
        else      t = cnt_t'(code) + cnt_t'(1);
        return t;
    endfunction

endpackage

// File: rtl/window_cmp.sv
module window_cmp
    import sense_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] sample,
    input  logic [W-1:0] thr_hi,
    input  logic [W-1:0] thr_lo,
    output win_e         pos
);
    logic above;
    logic below;

    always_comb begin
        above = (sample > thr_hi);
        below = (sample < thr_lo);
        if (above)      pos = WIN_ABOVE;
        else if (below) pos = WIN_BELOW;
        else            pos = WIN_IN;
    end
endmodule

// File: rtl/persist_filter.sv
module persist_filter
    import sense_irq_pkg::*;
#(
    parameter logic POW2 = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       shut,
    input  logic       int_en,
    input  win_e       pos,
    input  logic [1:0] code,
    output evt_t       evt
);
    localparam cnt_t CNT_MAX = '1;

    cnt_t cnt_q;
    win_e dir_q;
    cnt_t cnt_inc;
    cnt_t target;
    logic same_dir;
    logic fire;

    always_comb begin
        target   = persist_target(POW2, code);
        same_dir = (pos == dir_q) && (cnt_q != '0);
        if (!same_dir)             cnt_inc = cnt_t'(1);
        else if (cnt_q == CNT_MAX) cnt_inc = CNT_MAX;
        else                       cnt_inc = cnt_q + cnt_t'(1);
        fire        = valid && !shut && int_en && (pos != WIN_IN) && (cnt_inc >= target);
        evt.fire_hi = fire && (pos == WIN_ABOVE);
        evt.fire_lo = fire && (pos == WIN_BELOW);
    end

    always_ff @(posedge clk) begin
        if (rst || shut) begin
            cnt_q <= '0;
            dir_q <= WIN_IN;
        end else if (valid) begin
            if (pos == WIN_IN) begin
                cnt_q <= '0;
                dir_q <= WIN_IN;
            end else begin
                cnt_q <= cnt_inc;
                dir_q <= pos;
            end
        end
    end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import sense_irq_pkg::*;
#(
    parameter logic [FLAG_W-1:0] RSV = RSV_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] set,
    input  logic              rd,
    output logic [FLAG_W-1:0] flags,
    output logic              int_n
);
    logic [FLAG_W-1:0] q;

    for (genvar g = 0; g < FLAG_W; g++) begin : g_bit
        if (RSV[g]) begin : g_rsv
            assign flags[g] = 1'b0;
            always_ff @(posedge clk) q[g] <= 1'b0;
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (rst) q[g] <= 1'b0;
                else     q[g] <= (q[g] & ~rd) | set[g];
            end
            assign flags[g] = q[g];
        end
    end

    assign int_n = ~(|flags);
endmodule

// File: rtl/sense_irq_top.sv
module sense_irq_top
    import sense_irq_pkg::*;
#(
    parameter int AMB_W = 16,
    parameter int PRX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              amb_valid,
    input  logic [AMB_W-1:0]  amb_sample,
    input  logic [AMB_W-1:0]  amb_thr_hi,
    input  logic [AMB_W-1:0]  amb_thr_lo,
    input  logic [1:0]        amb_pers,
    input  logic              amb_int_en,
    input  logic              amb_shut,
    input  logic              prx_valid,
    input  logic [PRX_W-1:0]  prx_sample,
    input  logic [PRX_W-1:0]  prx_thr_hi,
    input  logic [PRX_W-1:0]  prx_thr_lo,
    input  logic [1:0]        prx_pers,
    input  logic              prx_int_en,
    input  logic              prx_shut,
    input  logic              sun_int_en,
    input  logic              sun_enter,
    input  logic              sun_leave,
    input  logic              flag_rd,
    output logic [7:0]        flags,
    output logic              int_n
);
    win_e              amb_pos;
    win_e              prx_pos;
    evt_t              amb_evt;
    evt_t              prx_evt;
    logic [FLAG_W-1:0] set_vec;

    window_cmp #(.W(AMB_W)) u_amb_cmp (
        .sample (amb_sample),
        .thr_hi (amb_thr_hi),
        .thr_lo (amb_thr_lo),
        .pos    (amb_pos)
    );

    persist_filter #(.POW2(1'b1)) u_amb_pf (
        .clk    (clk),
        .rst    (rst),
        .valid  (amb_valid),
        .shut   (amb_shut),
        .int_en (amb_int_en),
        .pos    (amb_pos),
        .code   (amb_pers),
        .evt    (amb_evt)
    );

    window_cmp #(.W(PRX_W)) u_prx_cmp (
        .sample (prx_sample),
        .thr_hi (prx_thr_hi),
        .thr_lo (prx_thr_lo),
        .pos    (prx_pos)
    );

    persist_filter #(.POW2(1'b0)) u_prx_pf (
        .clk    (clk),
        .rst    (rst),
        .valid  (prx_valid),
        .shut   (prx_shut),
        .int_en (prx_int_en),
        .pos    (prx_pos),
        .code   (prx_pers),
        .evt    (prx_evt)
    );

    always_comb begin
        set_vec               = '0;
        set_vec[FB_AMB_HI]    = amb_evt.fire_hi;
        set_vec[FB_AMB_LO]    = amb_evt.fire_lo;
        set_vec[FB_PRX_CLOSE] = prx_evt.fire_hi;
        set_vec[FB_PRX_AWAY]  = prx_evt.fire_lo;
        set_vec[FB_SUN_ENTER] = sun_int_en && sun_enter;
        set_vec[FB_SUN_LEAVE] = sun_int_en && sun_leave;
    end

    flag_reg #(.RSV(RSV_MASK)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (set_vec),
        .rd    (flag_rd),
        .flags (flags),
        .int_n (int_n)
    );
endmodule

// File: rtl/sense_irq_chk.sv
module sense_irq_chk #(
    parameter int AMB_W = 16,
    parameter int PRX_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              amb_valid,
    input logic [AMB_W-1:0]  amb_sample,
    input logic [AMB_W-1:0]  amb_thr_hi,
    input logic [AMB_W-1:0]  amb_thr_lo,
    input logic [1:0]        amb_pers,
    input logic              amb_int_en,
    input logic              amb_shut,
    input logic              prx_valid,
    input logic [PRX_W-1:0]  prx_sample,
    input logic [PRX_W-1:0]  prx_thr_hi,
    input logic [PRX_W-1:0]  prx_thr_lo,
    input logic [1:0]        prx_pers,
    input logic              prx_int_en,
    input logic              prx_shut,
    input logic              sun_int_en,
    input logic              sun_enter,
    input logic              sun_leave,
    input logic              flag_rd,
    input logic [7:0]        flags,
    input logic              int_n
);
    AST_AMB_SINGLE_HI: assert property (@(posedge clk) disable iff (rst)
        (amb_valid && !amb_shut && amb_int_en && amb_pers == 2'd0 && amb_sample > amb_thr_hi)
        |=> flags[4]); // R1

    AST_AMB_SHUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        amb_shut |=> ((flags & ~$past(flags) & 8'h30) == 8'h00)); // R6

    AST_PRX_GATE: assert property (@(posedge clk) disable iff (rst)
        (prx_shut || !prx_int_en) |=> ((flags & ~$past(flags) & 8'h03) == 8'h00)); // R7

    AST_SUN_GATE: assert property (@(posedge clk) disable iff (rst)
        !sun_int_en |=> ((flags & ~$past(flags) & 8'hC0) == 8'h00)); // R7

    AST_PRX_HYST: assert property (@(posedge clk) disable iff (rst)
        (prx_valid && prx_sample <= prx_thr_hi && prx_sample >= prx_thr_lo)
        |=> ((flags & ~$past(flags) & 8'h03) == 8'h00)); // R3

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !flag_rd |=> (($past(flags) & ~flags) == 8'h00)); // R9

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (flag_rd && !amb_valid && !prx_valid && !sun_enter && !sun_leave)
        |=> (flags == 8'h00 && int_n)); // R10

    AST_PERS_UNUSED_OK: assert property (@(posedge clk) disable iff (rst)
        (sun_int_en && sun_enter) |=> flags[6]); // R8
endmodule

bind sense_irq_top sense_irq_chk #(.AMB_W(AMB_W), .PRX_W(PRX_W)) i_chk (.*);

// File: tb/test_sense_irq_top.sv
`timescale 1ns/1ps
module test_sense_irq_top;
    localparam int AW = 6;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          amb_valid, amb_int_en, amb_shut;
    logic [AW-1:0] amb_sample, amb_thr_hi, amb_thr_lo;
    logic [1:0]    amb_pers, prx_pers;
    logic          prx_valid, prx_int_en, prx_shut;
    logic [PW-1:0] prx_sample, prx_thr_hi, prx_thr_lo;
    logic          sun_int_en, sun_enter, sun_leave, flag_rd;
    logic [7:0]    flags;
    logic          int_n;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sense_irq_top #(.AMB_W(AW), .PRX_W(PW)) i_sense_irq_top (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s flags act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input logic exp);
        n_chk++;
        if (int_n !== exp) begin
            n_bad++;
            $display("FAIL %s int_n act=%b exp=%b", tag, int_n, exp);
        end
    endtask

    task automatic amb_push(input logic [AW-1:0] v);
        amb_sample = v; amb_valid = 1'b1; tick(); amb_valid = 1'b0;
    endtask

    task automatic prx_push(input logic [PW-1:0] v);
        prx_sample = v; prx_valid = 1'b1; tick(); prx_valid = 1'b0;
    endtask

    task automatic clear_flags();
        flag_rd = 1'b1; tick(); flag_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] e;
        int n;
        rst = 1'b1; amb_valid = 0; prx_valid = 0; amb_sample = 0; prx_sample = 0;
        amb_thr_hi = 0; amb_thr_lo = 0; prx_thr_hi = 0; prx_thr_lo = 0;
        amb_pers = 0; prx_pers = 0; amb_int_en = 1; prx_int_en = 1; sun_int_en = 1;
        amb_shut = 0; prx_shut = 0; sun_enter = 0; sun_leave = 0; flag_rd = 0;
        repeat (3) tick();
        chk("R11 reset flags", flags, 8'h00);
        chk_int("R11 reset int", 1'b1);
        rst = 1'b0;

        // R1 ambient sweep, persistence 1
        for (int h = 0; h < 64; h += 21) begin
            for (int l = 0; l < 64; l += 21) begin
                amb_thr_hi = AW'(h); amb_thr_lo = AW'(l);
                for (int s = 0; s < 64; s++) begin
                    amb_push(AW'(s));
                    e = (s > h) ? 8'h10 : (s < l) ? 8'h20 : 8'h00;
                    chk("R1 ambient window", flags, e);
                    chk_int("R9 int follows flags", (e == 8'h00));
                    clear_flags();
                end
            end
        end

        // R3 proximity exhaustive sweep
        for (int h = 0; h < 16; h++) begin
            for (int l = 0; l < 16; l++) begin
                prx_thr_hi = PW'(h); prx_thr_lo = PW'(l);
                for (int s = 0; s < 16; s++) begin
                    prx_push(PW'(s));
                    e = (s > h) ? 8'h02 : (s < l) ? 8'h01 : 8'h00;
                    chk("R3 proximity window", flags, e);
                    clear_flags();
                end
            end
        end

        // R2 ambient persistence 1/2/4/8
        amb_thr_hi = 6'd40; amb_thr_lo = 6'd10;
        for (int c = 0; c < 4; c++) begin
            amb_pers = 2'(c); n = 1 << c;
            amb_push(6'd20);
            for (int k = 1; k < n; k++) begin
                amb_push(6'd50);
                chk("R2 ambient run short", flags, 8'h00);
            end
            amb_push(6'd50);
            chk("R2 ambient run complete", flags, 8'h10);
            clear_flags();
            amb_push(6'd50);
            chk("R2 ambient run continues", flags, 8'h10);
            clear_flags();
        end

        // R4 proximity persistence 1/2/3/4
        prx_thr_hi = 4'd10; prx_thr_lo = 4'd4;
        for (int c = 0; c < 4; c++) begin
            prx_pers = 2'(c); n = c + 1;
            prx_push(4'd7);
            for (int k = 1; k < n; k++) begin
                prx_push(4'd2);
                chk("R4 proximity run short", flags, 8'h00);
            end
            prx_push(4'd2);
            chk("R4 proximity run complete", flags, 8'h01);
            clear_flags();
        end

        // R5 in-window break and side change
        amb_pers = 2'd2;
        amb_push(6'd20);
        repeat (3) amb_push(6'd50);
        amb_push(6'd20);
        repeat (3) amb_push(6'd50);
        chk("R5 in-window resets run", flags, 8'h00);
        amb_push(6'd50);
        chk("R5 run after reset", flags, 8'h10);
        clear_flags();
        amb_pers = 2'd1;
        amb_push(6'd20);
        amb_push(6'd50);
        amb_push(6'd5);
        chk("R5 side change restarts", flags, 8'h00);
        amb_push(6'd5);
        chk("R5 low run complete", flags, 8'h20);
        clear_flags();

        // R6 shut down
        amb_pers = 2'd0; amb_shut = 1'b1;
        repeat (3) amb_push(6'd50);
        chk("R6 ambient shut quiet", flags, 8'h00);
        amb_shut = 1'b0; amb_pers = 2'd1;
        amb_push(6'd20);
        amb_push(6'd50);
        amb_shut = 1'b1; tick(); amb_shut = 1'b0;
        amb_push(6'd50);
        chk("R6 shut clears run", flags, 8'h00);
        amb_push(6'd50);
        chk("R6 run after wake", flags, 8'h10);
        clear_flags();
        prx_pers = 2'd0; prx_shut = 1'b1;
        prx_push(4'd12);
        chk("R6 proximity shut quiet", flags, 8'h00);
        prx_shut = 1'b0;

        // R7 enables
        amb_pers = 2'd0; amb_int_en = 1'b0;
        amb_push(6'd50);
        chk("R7 ambient disabled", flags, 8'h00);
        amb_int_en = 1'b1; prx_int_en = 1'b0;
        prx_push(4'd12);
        chk("R7 proximity disabled", flags, 8'h00);
        prx_int_en = 1'b1; sun_int_en = 1'b0;
        sun_enter = 1'b1; sun_leave = 1'b1; tick(); sun_enter = 1'b0; sun_leave = 1'b0;
        chk("R7 sunlight disabled", flags, 8'h00);
        chk_int("R7 int stays high", 1'b1);
        sun_int_en = 1'b1;

        // R8 sunlight events
        sun_enter = 1'b1; tick(); sun_enter = 1'b0;
        chk("R8 enter", flags, 8'h40);
        clear_flags();
        sun_leave = 1'b1; tick(); sun_leave = 1'b0;
        chk("R8 leave", flags, 8'h80);
        clear_flags();

        // R9 sticky and accumulation
        amb_push(6'd50);
        amb_push(6'd20);
        amb_push(6'd20);
        chk("R9 sticky", flags, 8'h10);
        prx_push(4'd12);
        chk("R9 accumulate", flags, 8'h12);
        chk_int("R9 int low", 1'b0);

        // R10 read colliding with a new event
        flag_rd = 1'b1; sun_leave = 1'b1; tick(); flag_rd = 1'b0; sun_leave = 1'b0;
        chk("R10 new event wins", flags, 8'h80);
        clear_flags();
        chk("R10 read clears", flags, 8'h00);
        chk_int("R10 int released", 1'b1);

        // R12 latency
        amb_sample = 6'd50; amb_valid = 1'b1;
        #2;
        chk("R12 not before edge", flags, 8'h00);
        @(posedge clk); #1;
        amb_valid = 1'b0;
        chk("R12 after edge", flags, 8'h10);
        tick();
        clear_flags();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule